// File: doc/BRIEF.md
# Pointer-Indexed Serial Console Port

This block is a small console controller that sits on a simple synchronous host bus and exposes two byte-wide registers: a status/command register at offset 0x80 and a data register at offset 0xC0. Writing the data register hands a byte to a transmit sink. Reading the data register takes the oldest byte from a small receive buffer, which a byte source fills through a valid/ready handshake. Line timing and character framing are handled elsewhere.

Status reads are indexed by a pointer byte. Every write to the status register loads that byte into the pointer. When the pointer holds 3, the next status read returns an event-cause byte and then sets the pointer back to 0. Any other pointer value gives a plain status byte. A single interrupt line reports pending transmit-done and receive-available events. A transmit event stays pending until the host writes the acknowledge code 0x28 to the status register. A receive event clears by itself once the host has drained the buffer.

Every read returns its data one cycle after the read strobe, together with a valid pulse. Two one-cycle error pulses flag protocol misuse.

Top module: `sercon_port`

## Requirements
- R1: After reset the pointer is 0, both pending flags are clear, `irq` is low, `rxReady` is high, and a status read returns 0x04.
- R2: Any write to the status register (offset 0x80) stores the whole written byte as the pointer, and the pointer then selects the view of the next status read.
- R3: A status read while the pointer equals 3 returns 0x10 (bit 4) if a transmit event is pending, otherwise 0x20 (bit 5) if a receive event is pending, otherwise 0x00. It also sets the pointer to 0.
- R4: A status read with any pointer value other than 3 returns 0x04 (bit 2), with bit 0 also set when a receive event is pending. The pointer is left unchanged.
- R5: A write to the data register (offset 0xC0) places the byte on `txData` with a one-cycle `txValid` pulse in the next cycle, and sets the transmit-pending flag.
- R6: Writing 0x28 to the status register clears the transmit-pending flag. If no transmit event was pending, `protoErr` pulses high for exactly one cycle.
- R7: A receive byte accepted (`rxValid` and `rxReady` both high at a clock edge) sets the receive-pending flag.
- R8: A data-register read returns the oldest buffered byte. The receive-pending flag clears only when that read empties the buffer.
- R9: A data-register read with an empty buffer returns 0x00 and pulses `emptyErr` for one cycle. It does not stall.
- R10: `irq` is high exactly when a transmit or a receive event is pending.
- R11: With RX_DEPTH bytes buffered, `rxReady` is low and an offered byte is not taken. Space freed by a read is usable again, with the buffer wrapping around.
- R12: Every read gives `busRvalid` one cycle later. Reads of unmapped offsets return 0x00, and writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busRdEn | input | 1 | Read strobe for one cycle |
| busWrEn | input | 1 | Write strobe for one cycle |
| busAddr | input | ADDR_W | Register offset |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid with busRvalid |
| busRvalid | output | 1 | Read data valid, one cycle after the read strobe |
| rxData | input | 8 | Receive byte from the source |
| rxValid | input | 1 | Receive byte offered |
| rxReady | output | 1 | Buffer can take a byte |
| txData | output | 8 | Transmit byte to the sink |
| txValid | output | 1 | Transmit byte strobe |
| irq | output | 1 | Interrupt, transmit or receive event pending |
| protoErr | output | 1 | Acknowledge without a pending transmit event |
| emptyErr | output | 1 | Data read from an empty buffer |

## Verification
The bench builds the block with RX_DEPTH set to 3. A depth that is not a power of two makes the buffer's read and write indices wrap explicitly. A full buffer is also reached within a few bytes, so the refused-byte case and a second fill after a full drain are both cheap to exercise. The offsets, the acknowledge code and the pointer select value keep their defaults, so the bench drives the exact byte values the requirements name.

// File: rtl/sercon_pkg.sv
package sercon_pkg;

  // bit positions inside the status byte
  localparam int unsigned TX_CAUSE_BIT = 4;
  localparam int unsigned RX_CAUSE_BIT = 5;
  localparam int unsigned BASE_BIT     = 2;
  localparam int unsigned RX_READY_BIT = 0;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic rxPush;      // take the offered receive byte
    logic rxPop;       // drop the head byte of the receive buffer
    logic txSend;      // launch the written byte to the sink
    logic rdStat;      // status register read
    logic statCause;   // status read uses the event-cause view
    logic rdData;      // data register read
    logic rdOther;     // read of an unmapped offset
  } ctlStrobe_t;

endpackage

// File: rtl/sercon_ctrl.sv
module sercon_ctrl
  import sercon_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h80,
  parameter logic [ADDR_W-1:0] DATA_OFS = 8'hC0,
  parameter logic [7:0] ACK_CODE = 8'h28,
  parameter logic [7:0] PTR_SEL  = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRdEn,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  input  logic              rxValid,
  input  logic              rxFull,
  input  logic              rxEmpty,
  input  logic              rxLast,
  output ctlStrobe_t        strobe,
  output logic              rxReady,
  output logic              txPend,
  output logic              rxPend,
  output logic              protoErr,
  output logic              emptyErr
);

  logic statHit, dataHit;
  logic statWr, statRd, dataWr, dataRd;
  logic ackWr;
  logic [7:0] ptrQ;

  assign statHit = (busAddr == STAT_OFS);
  assign dataHit = (busAddr == DATA_OFS);
  assign statWr  = busWrEn && statHit;
  assign statRd  = busRdEn && statHit;
  assign dataWr  = busWrEn && dataHit;
  assign dataRd  = busRdEn && dataHit;
  assign ackWr   = statWr && (busWdata == ACK_CODE);

  assign rxReady = !rxFull;

  always_comb begin
    strobe           = '0;
    strobe.rxPush    = rxValid && !rxFull;
    strobe.rxPop     = dataRd && !rxEmpty;
    strobe.txSend    = dataWr;
    strobe.rdStat    = statRd;
    strobe.statCause = statRd && (ptrQ == PTR_SEL);
    strobe.rdData    = dataRd;
    strobe.rdOther   = busRdEn && !statHit && !dataHit;
  end

  // pointer: any status write loads it, a cause-view read returns it to 0
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (statWr) begin
      ptrQ <= busWdata;
    end else if (strobe.statCause) begin
      ptrQ <= '0;
    end
  end

  // transmit event: set by a data write, cleared by the acknowledge code
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txPend <= 1'b0;
    end else if (dataWr) begin
      txPend <= 1'b1;
    end else if (ackWr) begin
      txPend <= 1'b0;
    end
  end

  // receive event: set on arrival, cleared when the last byte is taken
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxPend <= 1'b0;
    end else if (strobe.rxPush) begin
      rxPend <= 1'b1;
    end else if (strobe.rxPop && rxLast) begin
      rxPend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protoErr <= 1'b0;
      emptyErr <= 1'b0;
    end else begin
      protoErr <= ackWr && !txPend;
      emptyErr <= dataRd && rxEmpty;
    end
  end

  // R3: a cause-view read leaves the pointer at zero
  a_r3_ptr_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (statRd && (ptrQ == PTR_SEL) && !statWr) |=> (ptrQ == 8'h00));

  // R2: a status write is held in the pointer
  a_r2_ptr_loaded: assert property (@(posedge clk) disable iff (!rstN)
    statWr |=> (ptrQ == $past(busWdata)));

  // R5: a data write leaves a transmit event pending
  a_r5_tx_pending: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |=> txPend);

  // R6: acknowledge removes the transmit event
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    ackWr |=> !txPend);

  // R8: receive event tracks the buffer fill held in the datapath
  a_r8_pend_matches_fill: assert property (@(posedge clk) disable iff (!rstN)
    rxPend == !rxEmpty);

  // R12: the host bus issues one access per cycle
  a_r12_single_access: assert property (@(posedge clk) disable iff (!rstN)
    !(busRdEn && busWrEn));

endmodule

// File: rtl/sercon_dp.sv
module sercon_dp
  import sercon_pkg::*;
#(
  parameter int unsigned RX_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  logic [7:0] rxData,
  input  logic [7:0] busWdata,
  input  logic       txPend,
  input  logic       rxPend,
  output logic [7:0] busRdata,
  output logic       busRvalid,
  output logic [7:0] txData,
  output logic       txValid,
  output logic       rxFull,
  output logic       rxEmpty,
  output logic       rxLast
);

  localparam int unsigned IDX_W = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(RX_DEPTH + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RX_DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(RX_DEPTH);

  logic [7:0]       slotQ [RX_DEPTH];
  logic [IDX_W-1:0] wrIdx, rdIdx;
  logic [CNT_W-1:0] fillCnt;
  logic [7:0]       headByte;
  logic [7:0]       statView;

  assign rxEmpty  = (fillCnt == '0);
  assign rxFull   = (fillCnt == FULL_CNT);
  assign rxLast   = (fillCnt == CNT_W'(1));
  assign headByte = slotQ[rdIdx];

  // one storage slot per buffer entry
  for (genvar s = 0; s < RX_DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotQ[s] <= '0;
      end else if (strobe.rxPush && (wrIdx == IDX_W'(s))) begin
        slotQ[s] <= rxData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx   <= '0;
      rdIdx   <= '0;
      fillCnt <= '0;
    end else begin
      if (strobe.rxPush) begin
        wrIdx <= (wrIdx == LAST_IDX) ? '0 : wrIdx + IDX_W'(1);
      end
      if (strobe.rxPop) begin
        rdIdx <= (rdIdx == LAST_IDX) ? '0 : rdIdx + IDX_W'(1);
      end
      case ({strobe.rxPush, strobe.rxPop})
        2'b10:   fillCnt <= fillCnt + CNT_W'(1);
        2'b01:   fillCnt <= fillCnt - CNT_W'(1);
        default: fillCnt <= fillCnt;
      endcase
    end
  end

  // status byte for the current pointer view
  always_comb begin
    statView = '0;
    if (strobe.statCause) begin
      if (txPend) begin
        statView[TX_CAUSE_BIT] = 1'b1;
      end else if (rxPend) begin
        statView[RX_CAUSE_BIT] = 1'b1;
      end
    end else begin
      statView[BASE_BIT]     = 1'b1;
      statView[RX_READY_BIT] = rxPend;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata  <= '0;
      busRvalid <= 1'b0;
    end else begin
      busRvalid <= strobe.rdStat || strobe.rdData || strobe.rdOther;
      if (strobe.rdData) begin
        busRdata <= rxEmpty ? 8'h00 : headByte;
      end else if (strobe.rdStat) begin
        busRdata <= statView;
      end else begin
        busRdata <= 8'h00;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txData  <= '0;
      txValid <= 1'b0;
    end else begin
      txValid <= strobe.txSend;
      if (strobe.txSend) begin
        txData <= busWdata;
      end
    end
  end

  // R11: the buffer never holds more than its depth
  a_r11_fill_bound: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= FULL_CNT);

  // R11: control never pushes into a full buffer
  a_r11_no_push_full: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rxPush |-> !rxFull);

  // R8: control never pops an empty buffer
  a_r8_no_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rxPop |-> !rxEmpty);

  // R5: the sink sees the byte exactly one cycle after the write
  a_r5_tx_one_shot: assert property (@(posedge clk) disable iff (!rstN)
    txValid |=> (!txValid || $past(strobe.txSend)));

endmodule

// File: rtl/sercon_port.sv
module sercon_port
  import sercon_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned RX_DEPTH = 4,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h80,
  parameter logic [ADDR_W-1:0] DATA_OFS = 8'hC0,
  parameter logic [7:0] ACK_CODE = 8'h28,
  parameter logic [7:0] PTR_SEL  = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRdEn,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic              busRvalid,
  input  logic [7:0]        rxData,
  input  logic              rxValid,
  output logic              rxReady,
  output logic [7:0]        txData,
  output logic              txValid,
  output logic              irq,
  output logic              protoErr,
  output logic              emptyErr
);

  ctlStrobe_t strobe;
  logic txPend, rxPend;
  logic rxFull, rxEmpty, rxLast;

  sercon_ctrl #(
    .ADDR_W  (ADDR_W),
    .STAT_OFS(STAT_OFS),
    .DATA_OFS(DATA_OFS),
    .ACK_CODE(ACK_CODE),
    .PTR_SEL (PTR_SEL)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busRdEn (busRdEn),
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .rxValid (rxValid),
    .rxFull  (rxFull),
    .rxEmpty (rxEmpty),
    .rxLast  (rxLast),
    .strobe  (strobe),
    .rxReady (rxReady),
    .txPend  (txPend),
    .rxPend  (rxPend),
    .protoErr(protoErr),
    .emptyErr(emptyErr)
  );

  sercon_dp #(
    .RX_DEPTH(RX_DEPTH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rxData   (rxData),
    .busWdata (busWdata),
    .txPend   (txPend),
    .rxPend   (rxPend),
    .busRdata (busRdata),
    .busRvalid(busRvalid),
    .txData   (txData),
    .txValid  (txValid),
    .rxFull   (rxFull),
    .rxEmpty  (rxEmpty),
    .rxLast   (rxLast)
  );

  assign irq = txPend || rxPend;

  // R10: a data write raises the interrupt in the next cycle
  a_r10_irq_on_send: assert property (@(posedge clk) disable iff (!rstN)
    strobe.txSend |=> irq);

  // R10: a drained buffer with no transmit event leaves the line low
  a_r10_irq_low_idle: assert property (@(posedge clk) disable iff (!rstN)
    (rxEmpty && !txPend) |-> !irq);

endmodule

// File: tb/tb_sercon_port.sv
module tb_sercon_port;

  localparam int unsigned DEPTH = 3;
  localparam logic [7:0] A_STAT = 8'h80;
  localparam logic [7:0] A_DATA = 8'hC0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busRdEn = 1'b0, busWrEn = 1'b0;
  logic [7:0] busAddr = '0, busWdata = '0;
  logic [7:0] busRdata;
  logic busRvalid;
  logic [7:0] rxData = '0;
  logic rxValid = 1'b0;
  logic rxReady;
  logic [7:0] txData;
  logic txValid, irq, protoErr, emptyErr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // values captured after the most recent access
  logic [7:0] capRdata;
  logic capRvalid, capTxValid, capProto, capEmpty;
  logic [7:0] capTxData;

  always #10 clk = ~clk;

  sercon_port #(.RX_DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN),
    .busRdEn(busRdEn), .busWrEn(busWrEn), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busRvalid(busRvalid),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .txData(txData), .txValid(txValid),
    .irq(irq), .protoErr(protoErr), .emptyErr(emptyErr)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
    end
  endtask

  task automatic capture();
    capRdata   = busRdata;
    capRvalid  = busRvalid;
    capTxValid = txValid;
    capTxData  = txData;
    capProto   = protoErr;
    capEmpty   = emptyErr;
  endtask

  task automatic busWr(input logic [7:0] addr, input logic [7:0] data);
    busAddr = addr; busWdata = data; busWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
    capture();
  endtask

  task automatic busRd(input logic [7:0] addr);
    busAddr = addr; busRdEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busRdEn = 1'b0;
    capture();
  endtask

  task automatic readStat(input string req, input int expected);
    busRd(A_STAT);
    check(req, capRvalid, 1);
    check(req, capRdata, expected);
  endtask

  task automatic readData(input string req, input int expected);
    busRd(A_DATA);
    check(req, capRvalid, 1);
    check(req, capRdata, expected);
  endtask

  task automatic offerRx(input logic [7:0] b, input string req, input int expTaken);
    check(req, rxReady, expTaken);
    rxData = b; rxValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    capture();
  endtask

  task automatic t_reset();
    check("R1 irq", irq, 0);
    check("R1 rxReady", rxReady, 1);
    check("R1 protoErr", protoErr, 0);
    readStat("R1 status view", 8'h04);
  endtask

  task automatic t_transmit();
    busWr(A_DATA, 8'h5A);
    check("R5 txValid", capTxValid, 1);
    check("R5 txData", capTxData, 8'h5A);
    check("R10 irq on tx", irq, 1);
    idle();
    check("R5 txValid one cycle", capTxValid, 0);
    readStat("R4 base view with tx pending", 8'h04);
    busWr(A_STAT, 8'h03);
    readStat("R3 tx cause", 8'h10);
    readStat("R3 pointer back to zero", 8'h04);
    busWr(A_STAT, 8'h28);
    check("R6 ack no error", capProto, 0);
    check("R6 irq after ack", irq, 0);
    busWr(A_STAT, 8'h28);
    check("R6 ack without pending", capProto, 1);
    idle();
    check("R6 error one cycle", capProto, 0);
  endtask

  task automatic t_receive();
    offerRx(8'h11, "R7 ready", 1);
    check("R7 irq on arrival", irq, 1);
    offerRx(8'h22, "R7 ready", 1);
    busWr(A_STAT, 8'h03);
    readStat("R3 rx cause", 8'h20);
    readStat("R4 base view with rx", 8'h05);
    readData("R8 first byte", 8'h11);
    check("R8 still pending", irq, 1);
    readStat("R8 still pending view", 8'h05);
    readData("R8 second byte", 8'h22);
    check("R8 cleared when empty", irq, 0);
    readStat("R8 cleared view", 8'h04);
  endtask

  task automatic t_priority();
    offerRx(8'h33, "R7 ready", 1);
    busWr(A_DATA, 8'hA5);
    busWr(A_STAT, 8'h03);
    readStat("R3 tx wins over rx", 8'h10);
    busWr(A_STAT, 8'h28);
    check("R6 ack no error", capProto, 0);
    check("R10 irq held by rx", irq, 1);
    busWr(A_STAT, 8'h03);
    readStat("R3 rx after ack", 8'h20);
    readData("R8 drain", 8'h33);
    check("R10 irq low", irq, 0);
  endtask

  task automatic t_empty();
    readData("R9 empty read data", 8'h00);
    check("R9 emptyErr", capEmpty, 1);
    idle();
    check("R9 emptyErr one cycle", capEmpty, 0);
    check("R9 no irq", irq, 0);
  endtask

  task automatic t_full();
    for (int round = 0; round < 2; round++) begin
      for (int i = 0; i < DEPTH; i++) begin
        offerRx(8'h40 + 8'(round * 16 + i), "R11 ready before full", 1);
      end
      check("R11 not ready when full", rxReady, 0);
      offerRx(8'hEE, "R11 refused", 0);
      for (int i = 0; i < DEPTH; i++) begin
        readData("R11 order after wrap", 8'h40 + (round * 16 + i));
      end
      readData("R11 refused byte absent", 8'h00);
      check("R11 empty after drain", capEmpty, 1);
      check("R11 ready again", rxReady, 1);
    end
  endtask

  task automatic t_pointer();
    busWr(A_STAT, 8'h12);
    readStat("R2 other pointer view", 8'h04);
    readStat("R4 pointer kept", 8'h04);
    busWr(A_STAT, 8'h03);
    busRd(8'h40);
    check("R12 unmapped rvalid", capRvalid, 1);
    check("R12 unmapped data", capRdata, 0);
    busWr(8'h40, 8'h12);
    check("R12 unmapped write no tx", capTxValid, 0);
    readStat("R2 pointer held, idle cause", 8'h00);
    readStat("R3 pointer zero after cause", 8'h04);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_transmit();
    t_receive();
    t_priority();
    t_empty();
    t_full();
    t_pointer();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule